// File: doc/BRIEF.md
# Guest Instruction Trap Decision Unit

This block takes one decoded instruction at a time while the core runs a guest. It decides whether the instruction executes normally, takes a fault, or traps to the hypervisor. Each decision uses the instruction class, the primary and secondary execution-control words, the CR0 guest/host mask and read shadow, the CR4 value, a 64-bit enclave trap bitmap, the EAX value and a small vector of pending fault flags. Port I/O instructions are judged by a separate checker, and its verdict arrives on `io_trap_req`.

Each decision is launched with a one-cycle `in_valid` strobe. One cycle later `out_valid` pulses, together with a one-hot result and a fault code. Control-word bit positions are parameters. The defaults are listed below and the requirements refer to them.

Top module: `guest_trap_decider`

## Requirements
- R1: The result appears one cycle after `in_valid`. `out_valid` is high only in that cycle. While `out_valid` is low, and during reset, all result outputs are 0.
- R2: When `out_valid` is high, exactly one of `res_exec`, `res_fault`, `res_exit` is 1. `fault_code` is 0 unless `res_fault` is 1.
- R3: These class codes always trap: 1 identification, 3 cache invalidate without writeback, 4 extended-state write, 5 hypercall, 6 context load, 7 context store, 8 context clear, 9 launch, 10 resume, 11 virtualization off, 12 virtualization on, 13 and 14 the two TLB-invalidate forms.
- R4: Class 2 (secure-mode) traps when CR4 bit 14 is 1. When that bit is 0 it faults with code 4 (invalid opcode).
- R5: Class 15 (clear task-switched) traps only when bit 3 is 1 in both the CR0 mask and the CR0 read shadow.
- R6: Class 16 (enclave) traps only when secondary bit 15 is 1 and the bitmap bit selected by EAX is 1. EAX below 63 selects bit EAX. EAX of 63 or more selects bit 63.
- R7: Class 17 (halt) traps when primary bit 7 is 1. Class 18 (page invalidate) traps when primary bit 9 is 1.
- R8: Class 19 (process-context invalidate) traps only when primary bit 9 and secondary bit 12 are both 1.
- R9: When primary bit 31 is 0, every secondary control acts as 0.
- R10: Class 20 (port I/O) traps exactly when `io_trap_req` is 1. No other class reacts to `io_trap_req`.
- R11: Pending flags bit 0 (unusable segment), bit 1 (segment limit) and bit 2 (alignment) override every other outcome, in that order. They give fault codes 1, 2 and 3.
- R12: A trap overrides pending flag bit 3 (any other exception). Without a trap, that flag gives fault code 5. Classes not listed here, and classes whose trap condition is false, execute.
- R13: Class 21 (MSR read) traps when primary bit 28 is 1, even with flag bit 3 set for a nonexistent register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decision request strobe |
| instr_class | input | 5 | Instruction class code |
| ctl_primary | input | 32 | Primary execution-control word |
| ctl_secondary | input | 32 | Secondary execution-control word |
| cr0_mask | input | 64 | CR0 guest/host mask |
| cr0_shadow | input | 64 | CR0 read shadow |
| cr4_value | input | 64 | Current CR4 |
| encl_bitmap | input | 64 | Enclave trap bitmap |
| eax_value | input | 32 | EAX operand |
| io_trap_req | input | 1 | Verdict of the external port I/O checker |
| pend_flt | input | 4 | Pending fault flags |
| out_valid | output | 1 | Result valid |
| res_exec | output | 1 | Instruction executes normally |
| res_fault | output | 1 | Instruction faults |
| res_exit | output | 1 | Instruction traps to the hypervisor |
| fault_code | output | 3 | Fault cause when `res_fault` is 1 |

## Verification
The assertions assume the pending fault flags and controls are sampled only in the `in_valid` cycle. They also assume no second request is needed before the first result has been produced, which one strobe per cycle always satisfies. The stimulus asserts reset once at the start and then drives a fresh input set with every strobe. Random EAX values are mostly drawn near the 63 boundary, and pending flags are mostly zero, so that the trap rules, and not only the fault priorities, are exercised.

// File: rtl/gitd_pkg.sv
package gitd_pkg;

   localparam int CLS_W = 5;
   localparam int FC_W  = 3;

   localparam logic [CLS_W-1:0] C_PLAIN     = 5'd0;
   localparam logic [CLS_W-1:0] C_IDENT     = 5'd1;
   localparam logic [CLS_W-1:0] C_SECURE    = 5'd2;
   localparam logic [CLS_W-1:0] C_CINV      = 5'd3;
   localparam logic [CLS_W-1:0] C_XSTATE    = 5'd4;
   localparam logic [CLS_W-1:0] C_HCALL     = 5'd5;
   localparam logic [CLS_W-1:0] C_VLOAD     = 5'd6;
   localparam logic [CLS_W-1:0] C_VSTORE    = 5'd7;
   localparam logic [CLS_W-1:0] C_VCLEAR    = 5'd8;
   localparam logic [CLS_W-1:0] C_VLAUNCH   = 5'd9;
   localparam logic [CLS_W-1:0] C_VRESUME   = 5'd10;
   localparam logic [CLS_W-1:0] C_VOFF      = 5'd11;
   localparam logic [CLS_W-1:0] C_VON       = 5'd12;
   localparam logic [CLS_W-1:0] C_TLB_A     = 5'd13;
   localparam logic [CLS_W-1:0] C_TLB_B     = 5'd14;
   localparam logic [CLS_W-1:0] C_CLRTS     = 5'd15;
   localparam logic [CLS_W-1:0] C_ENCL      = 5'd16;
   localparam logic [CLS_W-1:0] C_HALT      = 5'd17;
   localparam logic [CLS_W-1:0] C_PGINV     = 5'd18;
   localparam logic [CLS_W-1:0] C_PCIDINV   = 5'd19;
   localparam logic [CLS_W-1:0] C_PORTIO    = 5'd20;
   localparam logic [CLS_W-1:0] C_MSRRD     = 5'd21;

   localparam logic [FC_W-1:0] FC_NONE     = 3'd0;
   localparam logic [FC_W-1:0] FC_GP_SEG   = 3'd1;
   localparam logic [FC_W-1:0] FC_GP_LIM   = 3'd2;
   localparam logic [FC_W-1:0] FC_ALIGN    = 3'd3;
   localparam logic [FC_W-1:0] FC_BADOP    = 3'd4;
   localparam logic [FC_W-1:0] FC_OTHER    = 3'd5;

   typedef struct packed {
      logic             run;
      logic             flt;
      logic             trp;
      logic [FC_W-1:0]  code;
   } verdict_t;

   function automatic logic always_traps(input logic [CLS_W-1:0] c);
      return (c == C_IDENT) || ((c >= C_CINV) && (c <= C_TLB_B));
   endfunction

endpackage

// File: rtl/gitd_ctl_gate.sv
module gitd_ctl_gate #(
   parameter int CTL_W    = 32,
   parameter int GATE_BIT = 31
) (
   input  logic [CTL_W-1:0] prim,
   input  logic [CTL_W-1:0] sec,
   output logic [CTL_W-1:0] sec_eff
);
   generate
      if (GATE_BIT >= CTL_W) begin : g_bad_gate
         $error("GATE_BIT outside control word");
      end
   endgenerate

   assign sec_eff = prim[GATE_BIT] ? sec : '0;
endmodule

// File: rtl/gitd_encl_match.sv
module gitd_encl_match #(
   parameter int BMP_W = 64,
   parameter int EAX_W = 32
) (
   input  logic [BMP_W-1:0] bitmap,
   input  logic [EAX_W-1:0] eax,
   output logic             hit
);
   localparam int TOP = BMP_W - 1;
   localparam logic [EAX_W-1:0] TOP_IDX = EAX_W'(TOP);

   logic [BMP_W-1:0] sel;

   generate
      if (BMP_W < 2) begin : g_bad_w
         $error("bitmap must hold at least two bits");
      end
      if (EAX_W < $clog2(BMP_W)) begin : g_bad_eax
         $error("EAX width too small to index bitmap");
      end
      for (genvar i = 0; i < BMP_W; i++) begin : g_bit
         if (i == TOP) begin : g_sat
            assign sel[i] = bitmap[i] & (eax >= TOP_IDX);
         end else begin : g_exact
            assign sel[i] = bitmap[i] & (eax == EAX_W'(i));
         end
      end
   endgenerate

   assign hit = |sel;
endmodule

// File: rtl/gitd_rule_eval.sv
module gitd_rule_eval
   import gitd_pkg::*;
#(
   parameter int CTL_W        = 32,
   parameter int REG_W        = 64,
   parameter int BMP_W        = 64,
   parameter int EAX_W        = 32,
   parameter int HLT_BIT      = 7,
   parameter int PGINV_BIT    = 9,
   parameter int MSR_BIT      = 28,
   parameter int ENCL_EN_BIT  = 15,
   parameter int PCID_EN_BIT  = 12,
   parameter int TS_BIT       = 3,
   parameter int SECURE_BIT   = 14
) (
   input  logic [CLS_W-1:0] cls,
   input  logic [CTL_W-1:0] prim,
   input  logic [CTL_W-1:0] sec_eff,
   input  logic [REG_W-1:0] cr0_mask,
   input  logic [REG_W-1:0] cr0_shadow,
   input  logic [REG_W-1:0] cr4,
   input  logic [BMP_W-1:0] bitmap,
   input  logic [EAX_W-1:0] eax,
   input  logic             io_req,
   output logic             trap_req,
   output logic             badop_req
);
   generate
      if (HLT_BIT >= CTL_W || PGINV_BIT >= CTL_W || MSR_BIT >= CTL_W ||
          ENCL_EN_BIT >= CTL_W || PCID_EN_BIT >= CTL_W) begin : g_bad_ctl
         $error("control bit outside control word");
      end
      if (TS_BIT >= REG_W || SECURE_BIT >= REG_W) begin : g_bad_reg
         $error("register bit outside register width");
      end
   endgenerate

   logic encl_hit;

   gitd_encl_match #(.BMP_W(BMP_W), .EAX_W(EAX_W)) u_encl (
      .bitmap (bitmap),
      .eax    (eax),
      .hit    (encl_hit)
   );

   always_comb begin
      trap_req  = 1'b0;
      badop_req = 1'b0;
      if (always_traps(cls)) begin
         trap_req = 1'b1;
      end else begin
         case (cls)
            C_SECURE: begin
               trap_req  = cr4[SECURE_BIT];
               badop_req = ~cr4[SECURE_BIT];
            end
            C_CLRTS:   trap_req = cr0_mask[TS_BIT] & cr0_shadow[TS_BIT];
            C_ENCL:    trap_req = sec_eff[ENCL_EN_BIT] & encl_hit;
            C_HALT:    trap_req = prim[HLT_BIT];
            C_PGINV:   trap_req = prim[PGINV_BIT];
            C_PCIDINV: trap_req = prim[PGINV_BIT] & sec_eff[PCID_EN_BIT];
            C_PORTIO:  trap_req = io_req;
            C_MSRRD:   trap_req = prim[MSR_BIT];
            default: begin
               trap_req  = 1'b0;
               badop_req = 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/gitd_prio.sv
module gitd_prio
   import gitd_pkg::*;
#(
   parameter int PEND_W = 4
) (
   input  logic              trap_req,
   input  logic              badop_req,
   input  logic [PEND_W-1:0] pend,
   output verdict_t          vd
);
   generate
      if (PEND_W != 4) begin : g_bad_pend
         $error("pending vector must carry four flags");
      end
   endgenerate

   always_comb begin
      vd = '{run: 1'b0, flt: 1'b0, trp: 1'b0, code: FC_NONE};
      if (pend[0]) begin
         vd.flt  = 1'b1;
         vd.code = FC_GP_SEG;
      end else if (pend[1]) begin
         vd.flt  = 1'b1;
         vd.code = FC_GP_LIM;
      end else if (pend[2]) begin
         vd.flt  = 1'b1;
         vd.code = FC_ALIGN;
      end else if (badop_req) begin
         vd.flt  = 1'b1;
         vd.code = FC_BADOP;
      end else if (trap_req) begin
         vd.trp  = 1'b1;
      end else if (pend[3]) begin
         vd.flt  = 1'b1;
         vd.code = FC_OTHER;
      end else begin
         vd.run  = 1'b1;
      end
   end
endmodule

// File: rtl/guest_trap_decider.sv
module guest_trap_decider
   import gitd_pkg::*;
#(
   parameter int CTL_W       = 32,
   parameter int REG_W       = 64,
   parameter int BMP_W       = 64,
   parameter int EAX_W       = 32,
   parameter int PEND_W      = 4,
   parameter int GATE_BIT    = 31,
   parameter int HLT_BIT     = 7,
   parameter int PGINV_BIT   = 9,
   parameter int MSR_BIT     = 28,
   parameter int ENCL_EN_BIT = 15,
   parameter int PCID_EN_BIT = 12,
   parameter int TS_BIT      = 3,
   parameter int SECURE_BIT  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [4:0]        instr_class,
   input  logic [CTL_W-1:0]  ctl_primary,
   input  logic [CTL_W-1:0]  ctl_secondary,
   input  logic [REG_W-1:0]  cr0_mask,
   input  logic [REG_W-1:0]  cr0_shadow,
   input  logic [REG_W-1:0]  cr4_value,
   input  logic [BMP_W-1:0]  encl_bitmap,
   input  logic [EAX_W-1:0]  eax_value,
   input  logic              io_trap_req,
   input  logic [PEND_W-1:0] pend_flt,
   output logic              out_valid,
   output logic              res_exec,
   output logic              res_fault,
   output logic              res_exit,
   output logic [2:0]        fault_code
);
   logic [CTL_W-1:0] sec_eff;
   logic             trap_req;
   logic             badop_req;
   verdict_t         vd;
   logic             unused_inputs;

   assign unused_inputs = ^{cr0_mask, cr0_shadow, cr4_value, ctl_primary, sec_eff};

   gitd_ctl_gate #(.CTL_W(CTL_W), .GATE_BIT(GATE_BIT)) u_gate (
      .prim    (ctl_primary),
      .sec     (ctl_secondary),
      .sec_eff (sec_eff)
   );

   gitd_rule_eval #(
      .CTL_W(CTL_W), .REG_W(REG_W), .BMP_W(BMP_W), .EAX_W(EAX_W),
      .HLT_BIT(HLT_BIT), .PGINV_BIT(PGINV_BIT), .MSR_BIT(MSR_BIT),
      .ENCL_EN_BIT(ENCL_EN_BIT), .PCID_EN_BIT(PCID_EN_BIT),
      .TS_BIT(TS_BIT), .SECURE_BIT(SECURE_BIT)
   ) u_rules (
      .cls        (instr_class),
      .prim       (ctl_primary),
      .sec_eff    (sec_eff),
      .cr0_mask   (cr0_mask),
      .cr0_shadow (cr0_shadow),
      .cr4        (cr4_value),
      .bitmap     (encl_bitmap),
      .eax        (eax_value),
      .io_req     (io_trap_req),
      .trap_req   (trap_req),
      .badop_req  (badop_req)
   );

   gitd_prio #(.PEND_W(PEND_W)) u_prio (
      .trap_req  (trap_req),
      .badop_req (badop_req),
      .pend      (pend_flt),
      .vd        (vd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         res_exec   <= 1'b0;
         res_fault  <= 1'b0;
         res_exit   <= 1'b0;
         fault_code <= FC_NONE;
      end else begin
         out_valid  <= in_valid;
         res_exec   <= in_valid & vd.run;
         res_fault  <= in_valid & vd.flt;
         res_exit   <= in_valid & vd.trp;
         fault_code <= in_valid ? vd.code : FC_NONE;
      end
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(res_exec || res_fault || res_exit) && fault_code == 3'd0); // R1
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot({res_exec, res_fault, res_exit})); // R2
   AST_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !res_fault |-> fault_code == 3'd0); // R2
   AST_UNCOND_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && always_traps(instr_class) && pend_flt[2:0] == 3'b000 |=> res_exit); // R3
   AST_SECURE_BADOP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && instr_class == C_SECURE && !cr4_value[SECURE_BIT] && pend_flt[2:0] == 3'b000
      |=> res_fault && fault_code == FC_BADOP); // R4
   AST_SEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !ctl_primary[GATE_BIT] && (instr_class == C_PCIDINV || instr_class == C_ENCL)
      |=> !res_exit); // R9
   AST_HIPRIO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && pend_flt[2:0] != 3'b000 |=> res_fault && fault_code >= 3'd1 && fault_code <= 3'd3); // R11
   AST_TRAP_OVER_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && always_traps(instr_class) && pend_flt == 4'b1000 |=> !res_fault); // R12
endmodule

// File: tb/guest_trap_decider_tb.sv
`timescale 1ns/1ps
module guest_trap_decider_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  instr_class = '0;
   logic [31:0] ctl_primary = '0;
   logic [31:0] ctl_secondary = '0;
   logic [63:0] cr0_mask = '0;
   logic [63:0] cr0_shadow = '0;
   logic [63:0] cr4_value = '0;
   logic [63:0] encl_bitmap = '0;
   logic [31:0] eax_value = '0;
   logic        io_trap_req = 1'b0;
   logic [3:0]  pend_flt = '0;
   logic        out_valid, res_exec, res_fault, res_exit;
   logic [2:0]  fault_code;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   guest_trap_decider u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr_class(instr_class),
      .ctl_primary(ctl_primary), .ctl_secondary(ctl_secondary),
      .cr0_mask(cr0_mask), .cr0_shadow(cr0_shadow), .cr4_value(cr4_value),
      .encl_bitmap(encl_bitmap), .eax_value(eax_value), .io_trap_req(io_trap_req),
      .pend_flt(pend_flt), .out_valid(out_valid), .res_exec(res_exec),
      .res_fault(res_fault), .res_exit(res_exit), .fault_code(fault_code)
   );

   // packed {valid, exec, fault, exit, code[2:0]}
   function automatic logic [6:0] model();
      logic trap = 1'b0;
      logic badop = 1'b0;
      logic [31:0] sec = ctl_primary[31] ? ctl_secondary : 32'd0;
      logic sel;
      int c = int'(instr_class);
      sel = (eax_value >= 32'd63) ? encl_bitmap[63] : encl_bitmap[eax_value[5:0]];
      if (c == 1 || (c >= 3 && c <= 14)) trap = 1'b1;
      else if (c == 2) begin trap = cr4_value[14]; badop = !cr4_value[14]; end
      else if (c == 15) trap = cr0_mask[3] && cr0_shadow[3];
      else if (c == 16) trap = sec[15] && sel;
      else if (c == 17) trap = ctl_primary[7];
      else if (c == 18) trap = ctl_primary[9];
      else if (c == 19) trap = ctl_primary[9] && sec[12];
      else if (c == 20) trap = io_trap_req;
      else if (c == 21) trap = ctl_primary[28];
      if (pend_flt[0])      return 7'b1_010_001;
      else if (pend_flt[1]) return 7'b1_010_010;
      else if (pend_flt[2]) return 7'b1_010_011;
      else if (badop)       return 7'b1_010_100;
      else if (trap)        return 7'b1_001_000;
      else if (pend_flt[3]) return 7'b1_010_101;
      return 7'b1_100_000;
   endfunction

   task automatic check(input string req, input logic [6:0] exp);
      logic [6:0] act = {out_valid, res_exec, res_fault, res_exit, fault_code};
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s class=%0d actual=%b expected=%b", req, instr_class, act, exp);
      end
   endtask

   task automatic defaults();
      ctl_primary = 32'h8000_0000; ctl_secondary = '0;
      cr0_mask = '0; cr0_shadow = '0; cr4_value = '0;
      encl_bitmap = '0; eax_value = '0; io_trap_req = 1'b0; pend_flt = '0;
   endtask

   // inputs already set; strobe one cycle and check at the following negedge
   task automatic fire(input string req);
      logic [6:0] exp = model();
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, exp);
   endtask

   task automatic fire_cls(input string req, input int c);
      instr_class = 5'(c);
      fire(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7311));
      defaults();
      repeat (3) @(negedge clk);
      check("R1 reset", 7'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: pulse only
      fire_cls("R1", 0);
      @(negedge clk);
      check("R1 idle", 7'b0);

      // R3
      for (int c = 1; c <= 14; c++) if (c != 2) fire_cls("R3", c);

      // R4
      cr4_value = 64'h1 << 14; fire_cls("R4 enabled", 2);
      cr4_value = ~(64'h1 << 14); fire_cls("R4 disabled", 2);
      check("R4", 7'b1_010_100);
      defaults();

      // R5
      cr0_mask = 64'h8; fire_cls("R5 mask only", 15);
      cr0_shadow = 64'h8; fire_cls("R5 both", 15);
      cr0_mask = 64'hFFFF_FFF7; fire_cls("R5 other bits", 15);
      defaults();

      // R6
      ctl_secondary = 32'h0000_8000;
      encl_bitmap = 64'h20; eax_value = 5; fire_cls("R6 index", 16);
      eax_value = 6; fire_cls("R6 index clear", 16);
      encl_bitmap = 64'h1 << 63; eax_value = 63; fire_cls("R6 bit63", 16);
      eax_value = 32'hFFFF_FFF0; fire_cls("R6 saturate", 16);
      encl_bitmap = 64'h4000_0000_0000_0000; eax_value = 100; fire_cls("R6 sat clear", 16);
      encl_bitmap = '1; ctl_secondary = '0; fire_cls("R6 disabled", 16);
      defaults();

      // R7, R8
      ctl_primary = 32'h8000_0080; fire_cls("R7 halt on", 17); fire_cls("R7 pg off", 18);
      ctl_primary = 32'h8000_0200; fire_cls("R7 pg on", 18); fire_cls("R7 halt off", 17);
      fire_cls("R8 pcid off", 19);
      ctl_secondary = 32'h0000_1000; fire_cls("R8 pcid on", 19);
      ctl_primary = 32'h8000_0000; fire_cls("R8 no pginv", 19);

      // R9
      ctl_primary = 32'h0000_0200; ctl_secondary = 32'hFFFF_FFFF;
      encl_bitmap = '1; fire_cls("R9 pcid", 19); fire_cls("R9 encl", 16);
      defaults();

      // R10
      io_trap_req = 1'b1; fire_cls("R10 io", 20);
      fire_cls("R10 halt ignores io", 17); fire_cls("R10 plain ignores io", 0);
      io_trap_req = 1'b0; fire_cls("R10 io off", 20);

      // R11
      pend_flt = 4'b1111; fire_cls("R11 seg", 1);
      pend_flt = 4'b1110; fire_cls("R11 limit", 1);
      pend_flt = 4'b1100; fire_cls("R11 align", 2);

      // R12, R13
      pend_flt = 4'b1000; fire_cls("R12 trap wins", 1);
      fire_cls("R12 other", 0);
      fire_cls("R13 msr off", 21);
      ctl_primary = 32'h9000_0000; fire_cls("R13 msr on", 21);
      pend_flt = '0; fire_cls("R12 plain", 25);
      defaults();

      // random mix
      for (int n = 0; n < 3000; n++) begin
         instr_class   = 5'($urandom_range(0, 25));
         ctl_primary   = $urandom();
         ctl_secondary = $urandom();
         cr0_mask      = {$urandom(), $urandom()};
         cr0_shadow    = {$urandom(), $urandom()};
         cr4_value     = {$urandom(), $urandom()};
         encl_bitmap   = {$urandom(), $urandom()};
         eax_value     = ($urandom_range(0, 3) == 0) ? $urandom() : $urandom_range(0, 70);
         io_trap_req   = 1'($urandom());
         pend_flt      = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'b0;
         fire("R2 random");
         if ($urandom_range(0, 7) == 0) begin
            @(negedge clk);
            check("R1 random idle", 7'b0);
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule